// File: doc/BRIEF.md
# Even-Ones Detector with Sequence Kill

This block watches a serial bit stream that arrives one bit per accepted cycle. Its single flag is high while the number of ones accepted since the last reset is even and greater than zero. Once the four consecutive accepted bits 0, 1, 0, 1 have appeared, the flag goes low and stays low until the next reset.

The block is a small controller with a datapath. A four-bit shift window holds the most recent accepted bits, and a comparator checks that window against the target pattern. A fill counter makes sure the comparator only counts a match once four real bits have entered the window since reset. A toggle flop tracks the parity of the ones count, and a separate flag records that at least one 1 has arrived. The output is registered. A bit accepted at one clock edge is reflected on the flag straight after that same edge.

Top module: `even_ones_gate`

## Requirements
- R1: While `rst` is high on a clock edge, the block clears its ones count, parity, window, fill count and kill state. `flag_out` reads 0 after that edge.
- R2: After an edge with `bit_vld`=1, `flag_out` is 1 when three conditions hold: the accepted ones count is even, the count is nonzero, and no kill has occurred since reset.
- R3: After an edge where `bit_vld`=1 leaves the accepted ones count odd, `flag_out` is 0.
- R4: While every bit accepted since reset has been 0, `flag_out` is 0.
- R5: Four consecutive accepted bits 0, 1, 0, 1, oldest first, drive `flag_out` to 0 after the edge that accepts the last of them. It then stays 0 for any later input until a reset. After a reset, R2 applies again.
- R6: On an edge with `bit_vld`=0, the value on `bit_in` has no effect. `flag_out` holds its value, and that bit does not count toward parity, the nonzero count or the pattern window.
- R7: A pattern match counts only once at least four bits have been accepted since reset. The cleared window never combines with fewer than four new bits to form a match. For example, 1, 0, 1 right after reset gives `flag_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` on this edge |
| flag_out | output | 1 | Registered even-and-nonzero flag, gated by the sticky kill |

## Verification
Every state element appears at the port on the next accepted bit:
- A parity flop stuck or inverted flips the flag after the first or second 1.
- A missing nonzero flag raises the flag on an all-zero stream.
- A kill that is not sticky brings the flag back on the next even count after 0101.
- A window or fill counter that is wrong either misses the kill or kills on a stream that is only three bits long after reset.
- A defect in valid gating shows on the first idle cycle that carries a 1.

The stimulus is laid out so that each of these faults changes the flag within a few accepted bits.

// File: rtl/even_ones_gate.sv
module even_ones_gate #(
  parameter int WIN_W = 4,
  parameter logic [WIN_W-1:0] TARGET = 4'b0101
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic flag_out
);
  localparam int FILL_W = $clog2(WIN_W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN_W);

  logic [WIN_W-1:0]  win, win_n;
  logic [FILL_W-1:0] fill, fill_n;
  logic odd, odd_n;
  logic seen_one, seen_n;
  logic killed, killed_n;
  logic match_n;

  assign win_n    = {win[WIN_W-2:0], bit_in};
  assign fill_n   = (fill == FILL_MAX) ? fill : fill + FILL_W'(1);
  assign odd_n    = odd ^ bit_in;
  assign seen_n   = seen_one | bit_in;
  assign match_n  = (fill_n == FILL_MAX) && (win_n == TARGET);
  assign killed_n = killed | match_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      win      <= '0;
      fill     <= '0;
      odd      <= 1'b0;
      seen_one <= 1'b0;
      killed   <= 1'b0;
      flag_out <= 1'b0;
    end else if (bit_vld) begin
      win      <= win_n;
      fill     <= fill_n;
      odd      <= odd_n;
      seen_one <= seen_n;
      killed   <= killed_n;
      flag_out <= !killed_n && seen_n && !odd_n;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !flag_out && !killed && !seen_one);
  assert_odd_low_R3:     assert property (@(posedge clk) disable iff (rst) odd |-> !flag_out);
  assert_no_ones_low_R4: assert property (@(posedge clk) disable iff (rst) !seen_one |-> !flag_out);
  assert_kill_low_R5:    assert property (@(posedge clk) disable iff (rst) killed |-> !flag_out);
  assert_idle_hold_R6:   assert property (@(posedge clk) disable iff (rst) !bit_vld |=> $stable(flag_out) && $stable(win));
  assert_fill_gate_R7:   assert property (@(posedge clk) disable iff (rst) (fill != FILL_MAX) |-> !killed);
endmodule

// File: tb/even_ones_gate_tb.sv
module even_ones_gate_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic flag_out;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  even_ones_gate u_dut (.clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .flag_out(flag_out));

  // entry: {req[3:0], vld, bit, expected flag}
  localparam int NV = 17;
  localparam logic [6:0] VEC [NV] = '{
    {4'd3, 1'b1, 1'b1, 1'b0},  // R3 one 1
    {4'd2, 1'b1, 1'b1, 1'b1},  // R2 two
    {4'd6, 1'b0, 1'b1, 1'b1},  // R6 idle 1 ignored
    {4'd3, 1'b1, 1'b1, 1'b0},  // R3 three
    {4'd2, 1'b1, 1'b1, 1'b1},  // R2 four
    {4'd2, 1'b1, 1'b0, 1'b1},
    {4'd2, 1'b1, 1'b0, 1'b1},
    {4'd3, 1'b1, 1'b1, 1'b0},
    {4'd2, 1'b1, 1'b1, 1'b1},  // six
    {4'd6, 1'b0, 1'b0, 1'b1},  // R6
    {4'd2, 1'b1, 1'b0, 1'b1},  // start 0101
    {4'd3, 1'b1, 1'b1, 1'b0},
    {4'd3, 1'b1, 1'b0, 1'b0},
    {4'd5, 1'b1, 1'b1, 1'b0},  // R5 match, count eight
    {4'd5, 1'b1, 1'b1, 1'b0},
    {4'd5, 1'b1, 1'b1, 1'b0},  // R5 even yet killed
    {4'd6, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input logic exp, input int req);
    n_chk++;
    if (flag_out !== exp) begin
      n_bad++;
      $display("FAIL R%0d flag_out actual=%b expected=%b", req, flag_out, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic exp, input int req);
    bit_vld = v;
    bit_in  = b;
    @(posedge clk);
    @(negedge clk);
    chk(exp, req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_vld = 1'b1;
    bit_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    bit_vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    chk(1'b0, 1);  // R1
    for (int i = 0; i < NV; i++)
      step(VEC[i][2], VEC[i][1], VEC[i][0], int'(VEC[i][6:3]));

    // R1 reset clears kill; R5 recovery
    do_reset();
    chk(1'b0, 1);
    step(1'b1, 1'b1, 1'b0, 5);
    step(1'b1, 1'b1, 1'b1, 5);

    // R4 zeros only
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 4);

    // R7 short stream must not match against cleared window
    do_reset();
    step(1'b1, 1'b1, 1'b0, 7);
    step(1'b1, 1'b0, 1'b0, 7);
    step(1'b1, 1'b1, 1'b1, 7);
    step(1'b1, 1'b1, 1'b0, 7);
    step(1'b1, 1'b1, 1'b1, 7);

    // R6 invalid 0101 and invalid ones ignored
    do_reset();
    step(1'b1, 1'b1, 1'b0, 6);
    step(1'b1, 1'b1, 1'b1, 6);
    step(1'b0, 1'b0, 1'b1, 6);
    step(1'b0, 1'b1, 1'b1, 6);
    step(1'b0, 1'b0, 1'b1, 6);
    step(1'b0, 1'b1, 1'b1, 6);
    step(1'b1, 1'b0, 1'b1, 6);
    step(1'b1, 1'b1, 1'b0, 6);
    step(1'b1, 1'b1, 1'b1, 6);

    finish_run();
  end
endmodule